// File: doc/BRIEF.md
# Configurable GPIO Port Controller

This block controls a bank of sixteen general-purpose pins from a 32-bit register interface. For every pin, software chooses a direction/function mode, a driver type, a pull resistor setting and a 4-bit alternate-function selector. A drive speed field is also stored, but it has no effect on any output. The block drives four pad control vectors: output enable, output value, pull-up enable and pull-down enable. It samples the pad levels through a two-stage synchronizer into an input data register.

Software changes the output data register in one of two ways. It can write the whole register, or it can write the set/clear register, which changes chosen bits in one step without a read-modify-write. A pin in alternate-function mode takes its output value from one of sixteen peripheral signals, picked by that pin's selector. In this mode the output data register has no effect on the pin.

The bus is a single-cycle register port. A write takes effect on the rising clock edge where `busWrEn` is high. Read data is combinational from `busAddr`.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every register reads 0. `padOe`, `padOut`, `padPullUp` and `padPullDn` are all 0, because every pin is in input mode with no pull.
- R2: Word addresses are: 0 mode, 1 driver type, 2 speed, 3 pull, 4 input data, 5 output data, 6 set/clear, 7 selectors for pins 0–7, 8 selectors for pins 8–15. The mode field of pin n is at bits [2n+1:2n]: 00 input, 01 output, 10 alternate, 11 analog. A pin in mode 01 or 10 with driver type bit n = 0 (push-pull) has `padOe` = 1 and `padOut` equal to its data bit.
- R3: A driving pin with driver type bit n = 1 (open-drain) keeps `padOut` at 0 and sets `padOe` to the inverse of its data bit.
- R4: The pull field of pin n is at bits [2n+1:2n]: 01 gives `padPullUp`, 10 gives `padPullDn`, and 00 or 11 gives neither.
- R5: Reading address 4 returns the pad levels in bits 15:0, two clock edges after they are applied. Bits 31:16 read 0.
- R6: In a write to address 6, a 1 in bit n sets output bit n, and a 1 in bit n+16 clears output bit n. Bits written as 0 leave the output unchanged.
- R7: When one write to address 6 sets both bit n and bit n+16, output bit n ends up 1.
- R8: Pin n's selector is at bits [4k+3:4k] of address 7 for n<8 (k=n), or of address 8 for n≥8 (k=n−8). In alternate mode, the pin's data bit is `altOut[selector]`, and the output data register does not affect the pin.
- R9: A pin in analog mode reads 0 in the input data register. Its `padOe`, `padOut` and both pull enables are 0.
- R10: Addresses 0–3, 5, 7 and 8 read back the last value written. Address 6 reads 0. The speed register does not change any pad output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, synchronous to `clk` |
| busAddr | input | 4 | Register word address |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for `busAddr` |
| padIn | input | 16 | Pad levels, asynchronous |
| altOut | input | 16 | Peripheral output signals available to the pins |
| padOe | output | 16 | Pad output enable per pin |
| padOut | output | 16 | Pad output value per pin |
| padPullUp | output | 16 | Pull-up enable per pin |
| padPullDn | output | 16 | Pull-down enable per pin |

## Verification
The checker assumes that `busAddr` and `busWrEn` are stable across each rising edge. It also assumes that a write to address 6 is the only bus action in its cycle, so the output register has one cause of change per edge. The stimulus meets both assumptions:
- All bus signals change only on the falling edge.
- The write strobe lasts exactly one cycle per write.

`padIn` and `altOut` also change only on falling edges. This keeps the synchronizer delay checks exact to the cycle.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_MODE   = 4'd0,
    A_TYPE   = 4'd1,
    A_SPEED  = 4'd2,
    A_PULL   = 4'd3,
    A_IDR    = 4'd4,
    A_ODR    = 4'd5,
    A_SETCLR = 4'd6,
    A_AFLO   = 4'd7,
    A_AFHI   = 4'd8
  } regAddr_e;

  // write strobes passed from control to datapath
  typedef struct packed {
    logic wrMode;
    logic wrType;
    logic wrSpeed;
    logic wrPull;
    logic wrOdr;
    logic wrSetClr;
    logic wrAfLo;
    logic wrAfHi;
  } regStrobe_t;

  localparam logic [1:0] MODE_IN  = 2'b00;
  localparam logic [1:0] MODE_OUT = 2'b01;
  localparam logic [1:0] MODE_ALT = 2'b10;
  localparam logic [1:0] MODE_ANA = 2'b11;

  localparam logic [1:0] PULL_UP = 2'b01;
  localparam logic [1:0] PULL_DN = 2'b10;

endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output regStrobe_t        strobe
);

  always_comb begin
    strobe = '0;
    if (busWrEn) begin
      case (busAddr)
        A_MODE:   strobe.wrMode   = 1'b1;
        A_TYPE:   strobe.wrType   = 1'b1;
        A_SPEED:  strobe.wrSpeed  = 1'b1;
        A_PULL:   strobe.wrPull   = 1'b1;
        A_ODR:    strobe.wrOdr    = 1'b1;
        A_SETCLR: strobe.wrSetClr = 1'b1;
        A_AFLO:   strobe.wrAfLo   = 1'b1;
        A_AFHI:   strobe.wrAfHi   = 1'b1;
        default:  strobe = '0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_bank_dp.sv
module gpio_bank_dp
  import gpio_bank_pkg::*;
#(
  parameter int PINS   = 16,
  parameter int AF_W   = 4,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  regStrobe_t            strobe,
  input  logic [ADDR_W-1:0]     rdAddr,
  input  logic [DATA_W-1:0]     wrData,
  output logic [DATA_W-1:0]     rdData,
  input  logic [PINS-1:0]       padIn,
  input  logic [(1<<AF_W)-1:0]  altOut,
  output logic [PINS-1:0]       padOe,
  output logic [PINS-1:0]       padOut,
  output logic [PINS-1:0]       padPullUp,
  output logic [PINS-1:0]       padPullDn
);

  localparam int FIELD2_W = 2 * PINS;
  localparam int AF_TOT   = AF_W * PINS;
  localparam int AF_HI_W  = AF_TOT - DATA_W;
  localparam int CLR_LSB  = DATA_W / 2;

  logic [FIELD2_W-1:0] modeQ, speedQ, pullQ;
  logic [PINS-1:0]     typeQ, odrQ, syncQ1, syncQ2, idrView;
  logic [AF_TOT-1:0]   afQ;

  // configuration and data registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ  <= '0;
      speedQ <= '0;
      pullQ  <= '0;
      typeQ  <= '0;
      odrQ   <= '0;
      afQ    <= '0;
    end else begin
      if (strobe.wrMode)  modeQ  <= wrData[FIELD2_W-1:0];
      if (strobe.wrSpeed) speedQ <= wrData[FIELD2_W-1:0];
      if (strobe.wrPull)  pullQ  <= wrData[FIELD2_W-1:0];
      if (strobe.wrType)  typeQ  <= wrData[PINS-1:0];
      if (strobe.wrAfLo)  afQ[DATA_W-1:0] <= wrData;
      if (strobe.wrAfHi)  afQ[AF_TOT-1:DATA_W] <= wrData[AF_HI_W-1:0];
      if (strobe.wrOdr)
        odrQ <= wrData[PINS-1:0];
      else if (strobe.wrSetClr)
        // clear first, then set: a set bit wins over its clear bit
        odrQ <= (odrQ & ~wrData[CLR_LSB +: PINS]) | wrData[PINS-1:0];
    end
  end

  // two-stage input synchronizer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ1 <= '0;
      syncQ2 <= '0;
    end else begin
      syncQ1 <= padIn;
      syncQ2 <= syncQ1;
    end
  end

  // per-pin pad control
  for (genvar i = 0; i < PINS; i++) begin : g_pin
    logic [1:0]      pinMode;
    logic [1:0]      pinPull;
    logic [AF_W-1:0] pinSel;
    logic            srcBit, drives, isAnalog;

    always_comb begin
      pinMode  = modeQ[2*i +: 2];
      pinPull  = pullQ[2*i +: 2];
      pinSel   = afQ[AF_W*i +: AF_W];
      isAnalog = (pinMode == MODE_ANA);
      drives   = (pinMode == MODE_OUT) || (pinMode == MODE_ALT);
      srcBit   = (pinMode == MODE_ALT) ? altOut[pinSel] : odrQ[i];
      padOe[i]     = drives & (typeQ[i] ? ~srcBit : 1'b1);
      padOut[i]    = drives & ~typeQ[i] & srcBit;
      padPullUp[i] = ~isAnalog & (pinPull == PULL_UP);
      padPullDn[i] = ~isAnalog & (pinPull == PULL_DN);
      idrView[i]   = syncQ2[i] & ~isAnalog;
    end
  end

  // read multiplexer
  always_comb begin
    case (rdAddr)
      A_MODE:  rdData = DATA_W'(modeQ);
      A_TYPE:  rdData = DATA_W'(typeQ);
      A_SPEED: rdData = DATA_W'(speedQ);
      A_PULL:  rdData = DATA_W'(pullQ);
      A_IDR:   rdData = DATA_W'(idrView);
      A_ODR:   rdData = DATA_W'(odrQ);
      A_AFLO:  rdData = afQ[DATA_W-1:0];
      A_AFHI:  rdData = DATA_W'(afQ[AF_TOT-1:DATA_W]);
      default: rdData = '0;
    endcase
  end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int PINS   = 16,
  parameter int AF_W   = 4,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic                  busWrEn,
  input  logic [DATA_W-1:0]     busWrData,
  output logic [DATA_W-1:0]     busRdData,
  input  logic [PINS-1:0]       padIn,
  input  logic [(1<<AF_W)-1:0]  altOut,
  output logic [PINS-1:0]       padOe,
  output logic [PINS-1:0]       padOut,
  output logic [PINS-1:0]       padPullUp,
  output logic [PINS-1:0]       padPullDn
);

  regStrobe_t strobe;

  gpio_bank_ctrl u_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strobe  (strobe)
  );

  gpio_bank_dp #(.PINS(PINS), .AF_W(AF_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .rdAddr    (busAddr),
    .wrData    (busWrData),
    .rdData    (busRdData),
    .padIn     (padIn),
    .altOut    (altOut),
    .padOe     (padOe),
    .padOut    (padOut),
    .padPullUp (padPullUp),
    .padPullDn (padPullDn)
  );

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int PINS   = 16,
  parameter int DATA_W = 32
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [ADDR_W-1:0]     busAddr,
  input logic                  busWrEn,
  input logic [DATA_W-1:0]     busWrData,
  input logic [DATA_W-1:0]     busRdData,
  input logic [PINS-1:0]       padOe,
  input logic [PINS-1:0]       padOut,
  input logic [PINS-1:0]       padPullUp,
  input logic [PINS-1:0]       padPullDn,
  input logic [PINS-1:0]       odr,
  input logic [2*PINS-1:0]     mode,
  input logic [PINS-1:0]       otype
);

  localparam int CLR_LSB = DATA_W / 2;

  logic [PINS-1:0] drvMask;
  for (genvar i = 0; i < PINS; i++) begin : g_mask
    assign drvMask[i] = (mode[2*i +: 2] == MODE_OUT) || (mode[2*i +: 2] == MODE_ALT);
  end

  logic scWr;
  assign scWr = busWrEn && (busAddr == A_SETCLR);

  AST_SETCLR_SET: assert property (@(posedge clk) disable iff (!rstN)
    scWr |=> ((odr & $past(busWrData[PINS-1:0])) == $past(busWrData[PINS-1:0])));  // R7

  AST_SETCLR_CLR: assert property (@(posedge clk) disable iff (!rstN)
    scWr |=> ((odr & $past(busWrData[CLR_LSB +: PINS]) & ~$past(busWrData[PINS-1:0])) == '0));  // R6

  AST_SETCLR_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    scWr |=> (((odr ^ $past(odr)) &
               ~($past(busWrData[PINS-1:0]) | $past(busWrData[CLR_LSB +: PINS]))) == '0));  // R6

  AST_NO_DRIVE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (padOe & ~drvMask) == '0);  // R9

  AST_PP_DRIVES: assert property (@(posedge clk) disable iff (!rstN)
    (drvMask & ~otype & ~padOe) == '0);  // R2

  AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (padOut & otype) == '0);  // R3

  AST_PULL_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    (padPullUp & padPullDn) == '0);  // R4

  AST_IDR_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == A_IDR) |-> (busRdData[DATA_W-1:CLR_LSB] == '0));  // R5

endmodule

bind gpio_bank gpio_bank_chk #(.PINS(PINS), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWrEn   (busWrEn),
  .busWrData (busWrData),
  .busRdData (busRdData),
  .padOe     (padOe),
  .padOut    (padOut),
  .padPullUp (padPullUp),
  .padPullDn (padPullDn),
  .odr       (u_dp.odrQ),
  .mode      (u_dp.modeQ),
  .otype     (u_dp.typeQ)
);

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb;

  localparam int CLK_NS = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [15:0] padIn = '0;
  logic [15:0] altOut = '0;
  logic [15:0] padOe, padOut, padPullUp, padPullDn;

  int  tests = 0;
  int  fails = 0;
  bit  finished = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  gpio_bank u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .padIn(padIn),
    .altOut(altOut), .padOe(padOe), .padOut(padOut),
    .padPullUp(padPullUp), .padPullDn(padPullDn)
  );

  // scoreboard item: sel 0 read data, 1 oe, 2 out, 3 pull-up, 4 pull-down
  typedef struct {
    int          sel;
    logic [31:0] exp;
    string       tag;
  } sbItem_t;

  sbItem_t sbQ[$];

  // monitor: pops expectations and compares, away from the rising edge
  initial begin
    forever begin
      @(negedge clk);
      #5;
      while (sbQ.size() > 0) begin
        sbItem_t it;
        logic [31:0] act;
        it = sbQ.pop_front();
        case (it.sel)
          0: act = busRdData;
          1: act = {16'h0, padOe};
          2: act = {16'h0, padOut};
          3: act = {16'h0, padPullUp};
          default: act = {16'h0, padPullDn};
        endcase
        tests++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s: sel %0d actual 0x%08h expected 0x%08h", it.tag, it.sel, act, it.exp);
        end
      end
    end
  end

  task automatic regWr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic expRd(input logic [3:0] a, input logic [31:0] e, input string tag);
    sbItem_t it;
    @(negedge clk);
    busAddr = a;
    it.sel = 0; it.exp = e; it.tag = tag;
    sbQ.push_back(it);
  endtask

  task automatic expPad(input int sel, input logic [15:0] e, input string tag);
    sbItem_t it;
    it.sel = sel; it.exp = {16'h0, e}; it.tag = tag;
    sbQ.push_back(it);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    #(CLK_NS * 20000);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    expRd(4'd0, 32'h0, "R1 mode");
    expRd(4'd5, 32'h0, "R1 odr");
    expPad(1, 16'h0, "R1 oe");
    expPad(2, 16'h0, "R1 out");
    expPad(3, 16'h0, "R1 pullup");
    expPad(4, 16'h0, "R1 pulldn");

    // R10 readback, all pins general output, speed has no effect
    regWr(4'd0, 32'h5555_5555);
    expRd(4'd0, 32'h5555_5555, "R10 mode");
    expPad(1, 16'hFFFF, "R2 oe pushpull");
    regWr(4'd2, 32'hDEAD_BEEF);
    expRd(4'd2, 32'hDEAD_BEEF, "R10 speed");
    expPad(1, 16'hFFFF, "R10 speed no effect oe");
    expPad(2, 16'h0000, "R10 speed no effect out");

    // R6 set/clear
    regWr(4'd5, 32'h0000_00F0);
    regWr(4'd6, {16'h0030, 16'h0F00});
    expRd(4'd5, 32'h0000_0FC0, "R6 odr");
    expPad(2, 16'h0FC0, "R2 out follows odr");
    expRd(4'd6, 32'h0, "R10 setclr reads 0");

    // R7 set wins
    regWr(4'd6, {16'h0001, 16'h0001});
    expRd(4'd5, 32'h0000_0FC1, "R7 set wins");

    // R3 open-drain on pins 0..3
    regWr(4'd1, 32'h0000_000F);
    expRd(4'd1, 32'h0000_000F, "R10 type");
    expPad(1, 16'hFFFE, "R3 oe");
    expPad(2, 16'h0FC0, "R3 out");

    // R4 pulls: pin0 up, pin1 down, pin2 reserved
    regWr(4'd3, 32'h0000_0039);
    expPad(3, 16'h0001, "R4 pullup");
    expPad(4, 16'h0002, "R4 pulldn");

    // R8 alternate function: pin0 sel 3, pin9 sel 12
    altOut = 16'h0008;
    regWr(4'd7, 32'h0000_0003);
    regWr(4'd8, 32'h0000_00C0);
    regWr(4'd0, 32'h5559_5556);
    expRd(4'd7, 32'h0000_0003, "R10 aflo");
    expRd(4'd8, 32'h0000_00C0, "R10 afhi");
    expPad(1, 16'hFFFE, "R8 oe alt");
    expPad(2, 16'h0DC0, "R8 out alt");
    @(negedge clk);
    altOut = 16'h1000;
    expPad(1, 16'hFFFF, "R8 oe alt swap");
    expPad(2, 16'h0FC0, "R8 out alt swap");

    // R5 input sampling, two edges
    @(negedge clk);
    padIn = 16'hA5C3;
    @(negedge clk);
    expRd(4'd4, 32'h0000_A5C3, "R5 idr");

    // R9 analog on pins 1..15, pin0 input
    regWr(4'd0, 32'hFFFF_FFFC);
    expRd(4'd4, 32'h0000_0001, "R9 idr analog");
    expPad(1, 16'h0000, "R9 oe");
    expPad(2, 16'h0000, "R9 out");
    expPad(3, 16'h0001, "R9 pullup");
    expPad(4, 16'h0000, "R9 pulldn");

    repeat (3) @(negedge clk);
    finished = 1'b1;
    summary();
    $finish;
  end

endmodule